// File: doc/BRIEF.md
# Overlay Horizontal Start Timer

This block times where an on-screen overlay begins on each scan line. It runs on the overlay oscillator clock. Software writes a 7-bit start position through a small register port. The write is held in a pending register and moves into the working position only on a rising edge of vertical sync, so the start point never shifts in the middle of a frame. Whenever the active edge of horizontal sync is seen, the block counts a fixed base delay of 62 cycles plus 4 cycles for each step of the working position. At the end of that count it emits a one-cycle start strobe.

The start strobe also launches a dot-clock enable divided by a selectable ratio of 1, 2 or 3. The first enable, marked as the first dot, comes one divided period after the strobe. Overlays that use different ratios therefore begin their leftmost dot at different points. The enable keeps running until the next active horizontal sync edge. Both sync inputs pass through two-stage synchronizers before edge detection. A polarity input selects which horizontal sync edge is the active one.

Top module: `hstart_timer`

## Requirements
- R1: After reset the working and pending positions are 0, `pos_rdata_o` reads 0, and `start_o`, `dot_en_o` and `first_dot_o` are low.
- R2: A write sets the pending position to `pos_wdata_i[6:0]`. `pos_rdata_o` returns the pending position in bits 6:0, and bit 7 always reads 0 whatever value was written to it.
- R3: A written position has no effect on the start delay until `vsync_i` rises. Lines timed before that edge keep the previous working position.
- R4: Number the rising clock edges, starting at 1 with the first edge at which the new level of `hsync_i` is present. On an active edge, `start_o` is high after edge 65+4N, where N is the working position (0..127).
- R5: With `hsync_rise_act_i`=1 only the rising edge of `hsync_i` is active. With 0, only the falling edge is active. The other edge produces no start strobe.
- R6: `start_o` is high for exactly one clock cycle per completed line.
- R7: An active edge that arrives before the count ends restarts the count from that edge. No strobe is issued for the aborted line.
- R8: `div_sel_i` selects the dot ratio: 1 gives 1, 2 gives 2, 3 gives 3, and 0 gives 1. The first `dot_en_o` pulse comes ratio cycles after the `start_o` cycle, with `first_dot_o` high in that same cycle.
- R9: Later `dot_en_o` pulses follow every ratio cycles with `first_dot_o` low. The ratio is captured with the strobe, and changes to `div_sel_i` after the strobe do not alter the spacing.
- R10: From the third clock edge after an active hsync edge is detected, `dot_en_o` stays low until the next start strobe.
- R11: `dot_en_o` is low in the cycle in which `start_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Overlay oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pos_wr_i | input | 1 | Position register write strobe |
| pos_wdata_i | input | 8 | Write data; bits 6:0 are the position and bit 7 is ignored |
| pos_rdata_o | output | 8 | Pending position readback; bit 7 is always 0 |
| vsync_i | input | 1 | Vertical sync; its rising edge applies the pending position |
| hsync_i | input | 1 | Horizontal sync, asynchronous |
| hsync_rise_act_i | input | 1 | 1: rising hsync edge active; 0: falling edge active |
| div_sel_i | input | 2 | Dot-clock pre-divide ratio select |
| start_o | output | 1 | One-cycle horizontal start strobe |
| dot_en_o | output | 1 | Divided dot-clock enable pulse |
| first_dot_o | output | 1 | Marks the leftmost dot of the line |

## Verification
The strobe is due 65+4N clock edges after the first edge that samples the new hsync level. That figure includes three register stages: two synchronizer stages and the edge-detect register that loads the counter. The first dot is due exactly ratio edges after the strobe cycle, and each later dot ratio edges after the one before. The bench drives each input just after a falling clock edge. It then counts rising edges one at a time and samples the outputs at the next falling edge, so each measured count is compared with the exact figure above rather than with a window.

// File: rtl/hst_pkg.sv
package hst_pkg;

    localparam int POS_W    = 7;
    localparam int BASE_DLY = 62;
    localparam int STEP_CYC = 4;
    localparam int MAX_DLY  = BASE_DLY + STEP_CYC * ((1 << POS_W) - 1);
    localparam int CNT_W    = $clog2(MAX_DLY + 1);
    localparam int RAT_W    = 2;

    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    typedef struct packed {
        logic [7:0]       pend;
        logic [POS_W-1:0] work;
    } pos_t;

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic             start;
    } dly_t;

    typedef struct packed {
        logic             run;
        logic [RAT_W-1:0] ratio;
        logic [RAT_W-1:0] phase;
        logic             first_pend;
        logic             dot;
        logic             first;
    } dot_t;

endpackage

// File: rtl/hst_edge_sync.sv
module hst_edge_sync
    import hst_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    input  logic rise_act_i,
    output logic act_o
);

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = sig_i;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act_o = rise_act_i ? (st_q.s2 & ~st_q.s3) : (~st_q.s2 & st_q.s3);

    // One active edge cannot be reported on two consecutive cycles
    p_edge_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        act_o |=> !act_o);

endmodule

// File: rtl/hst_pos_shadow.sv
module hst_pos_shadow
    import hst_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [7:0]       wdata_i,
    input  logic             apply_i,
    output logic [7:0]       rdata_o,
    output logic [POS_W-1:0] work_o
);

    localparam logic [7:0] WMASK = 8'((1 << POS_W) - 1);

    pos_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (apply_i) st_d.work = st_q.pend[POS_W-1:0];
        if (wr_i)    st_d.pend = wdata_i & WMASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata_o = st_q.pend;
    assign work_o  = st_q.work;

    // Working position only moves on a vertical sync edge
    p_work_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !apply_i |=> $stable(work_o));

endmodule

// File: rtl/hst_delay_cnt.sv
module hst_delay_cnt
    import hst_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_i,
    input  logic [POS_W-1:0] pos_i,
    output logic             fire_o,
    output logic             start_o
);

    dly_t st_d, st_q;
    logic [CNT_W-1:0] load_val;
    logic             fire;

    always_comb begin
        load_val = CNT_W'(BASE_DLY - 1) + CNT_W'(pos_i) * CNT_W'(STEP_CYC);
        fire     = st_q.busy && (st_q.cnt == '0) && !act_i;
        st_d       = st_q;
        st_d.start = 1'b0;
        if (act_i) begin
            st_d.busy = 1'b1;
            st_d.cnt  = load_val;
        end else if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.busy  = 1'b0;
                st_d.start = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fire_o  = fire;
    assign start_o = st_q.start;

    p_start_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);

    p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        act_i |=> !start_o);

    p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (st_q.cnt < CNT_W'(MAX_DLY)));

endmodule

// File: rtl/hst_dot_gen.sv
module hst_dot_gen
    import hst_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire_i,
    input  logic             stop_i,
    input  logic [RAT_W-1:0] div_i,
    output logic             dot_o,
    output logic             first_o
);

    dot_t st_d, st_q;
    logic [RAT_W-1:0] ratio_dec;

    always_comb begin
        ratio_dec  = (div_i == '0) ? RAT_W'(1) : div_i;
        st_d       = st_q;
        st_d.dot   = 1'b0;
        st_d.first = 1'b0;
        if (stop_i) begin
            st_d.run = 1'b0;
        end else if (fire_i) begin
            st_d.run        = 1'b1;
            st_d.ratio      = ratio_dec;
            st_d.phase      = ratio_dec - 1'b1;
            st_d.first_pend = 1'b1;
        end else if (st_q.run) begin
            if (st_q.phase == '0) begin
                st_d.dot        = 1'b1;
                st_d.first      = st_q.first_pend;
                st_d.first_pend = 1'b0;
                st_d.phase      = st_q.ratio - 1'b1;
            end else begin
                st_d.phase = st_q.phase - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dot_o   = st_q.dot;
    assign first_o = st_q.first;

    p_dots_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> ##1 !dot_o);

endmodule

// File: rtl/hstart_timer.sv
module hstart_timer
    import hst_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pos_wr_i,
    input  logic [7:0] pos_wdata_i,
    output logic [7:0] pos_rdata_o,
    input  logic       vsync_i,
    input  logic       hsync_i,
    input  logic       hsync_rise_act_i,
    input  logic [1:0] div_sel_i,
    output logic       start_o,
    output logic       dot_en_o,
    output logic       first_dot_o
);

    logic             hs_act;
    logic             vs_rise;
    logic             fire;
    logic [POS_W-1:0] work_pos;

    hst_edge_sync hs_sync_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sig_i      (hsync_i),
        .rise_act_i (hsync_rise_act_i),
        .act_o      (hs_act)
    );

    hst_edge_sync vs_sync_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sig_i      (vsync_i),
        .rise_act_i (1'b1),
        .act_o      (vs_rise)
    );

    hst_pos_shadow pos_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (pos_wr_i),
        .wdata_i (pos_wdata_i),
        .apply_i (vs_rise),
        .rdata_o (pos_rdata_o),
        .work_o  (work_pos)
    );

    hst_delay_cnt dly_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .act_i   (hs_act),
        .pos_i   (work_pos),
        .fire_o  (fire),
        .start_o (start_o)
    );

    hst_dot_gen dot_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire_i  (fire),
        .stop_i  (hs_act),
        .div_i   (div_sel_i),
        .dot_o   (dot_en_o),
        .first_o (first_dot_o)
    );

    p_no_dot_at_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> !dot_en_o);

    p_first_with_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> !first_dot_o);

endmodule

// File: tb/hstart_timer_tb_top.sv
`timescale 1ns/1ps
module hstart_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pos_wr_i = 1'b0;
    logic [7:0] pos_wdata_i = '0;
    logic [7:0] pos_rdata_o;
    logic       vsync_i = 1'b0;
    logic       hsync_i = 1'b0;
    logic       hsync_rise_act_i = 1'b1;
    logic [1:0] div_sel_i = 2'd1;
    logic       start_o, dot_en_o, first_dot_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    hstart_timer dut_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .pos_wr_i         (pos_wr_i),
        .pos_wdata_i      (pos_wdata_i),
        .pos_rdata_o      (pos_rdata_o),
        .vsync_i          (vsync_i),
        .hsync_i          (hsync_i),
        .hsync_rise_act_i (hsync_rise_act_i),
        .div_sel_i        (div_sel_i),
        .start_o          (start_o),
        .dot_en_o         (dot_en_o),
        .first_dot_o      (first_dot_o)
    );

    // {pos[21:15], div[14:13], rise_act[12], start edge count[11:2], dot lag[1:0]}
    localparam int NVEC = 6;
    localparam logic [21:0] VEC [NVEC] = '{
        {7'd0,   2'd1, 1'b1, 10'd65,  2'd1},
        {7'd1,   2'd2, 1'b0, 10'd69,  2'd2},
        {7'd5,   2'd3, 1'b1, 10'd85,  2'd3},
        {7'd64,  2'd0, 1'b0, 10'd321, 2'd1},
        {7'd127, 2'd2, 1'b1, 10'd573, 2'd2},
        {7'd33,  2'd3, 1'b0, 10'd197, 2'd3}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_pos(input logic [7:0] v);
        @(negedge clk);
        pos_wr_i = 1'b1; pos_wdata_i = v;
        @(negedge clk);
        pos_wr_i = 1'b0;
    endtask

    task automatic pulse_vsync();
        @(negedge clk); vsync_i = 1'b1;
        repeat (4) @(negedge clk);
        vsync_i = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // Count rising edges until an output is seen at the following falling edge
    task automatic wait_start(output int n);
        n = 0;
        for (int i = 0; i < 2000; i++) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (start_o) break;
        end
    endtask

    task automatic wait_dot(output int n);
        n = 0;
        for (int i = 0; i < 20; i++) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (dot_en_o) break;
        end
    endtask

    task automatic run_line(input logic rise, input logic [1:0] div, input logic [1:0] post_div,
                            input int exp_start, input int exp_ratio);
        int n, m, g;
        @(negedge clk);
        hsync_rise_act_i = rise;
        div_sel_i = div;
        hsync_i = rise ? 1'b0 : 1'b1;
        repeat (6) @(negedge clk);
        hsync_i = rise ? 1'b1 : 1'b0;
        wait_start(n);
        check(n == exp_start, "R4 start edge count", n, exp_start);
        check(dot_en_o == 1'b0, "R11 dot_en at start", int'(dot_en_o), 0);
        div_sel_i = post_div;
        @(posedge clk); @(negedge clk);
        check(start_o == 1'b0, "R6 start width", int'(start_o), 0);
        m = 1;
        if (!dot_en_o) begin
            wait_dot(n);
            m += n;
        end
        check(m == exp_ratio, "R8 first dot lag", m, exp_ratio);
        check(first_dot_o == 1'b1, "R8 first_dot flag", int'(first_dot_o), 1);
        wait_dot(g);
        check(g == exp_ratio, "R9 dot spacing", g, exp_ratio);
        check(first_dot_o == 1'b0, "R9 later dot flag", int'(first_dot_o), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n, cnt;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(start_o == 1'b0 && dot_en_o == 1'b0 && first_dot_o == 1'b0,
              "R1 outputs in reset", int'({start_o, dot_en_o, first_dot_o}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(pos_rdata_o == 8'h00, "R1 readback after reset", int'(pos_rdata_o), 0);
        check(start_o == 1'b0 && dot_en_o == 1'b0, "R1 outputs after reset",
              int'({start_o, dot_en_o}), 0);

        // R1: working position is 0 after reset -> 65 edges
        run_line(1'b1, 2'd1, 2'd1, 65, 1);

        // Vector table
        for (int v = 0; v < NVEC; v++) begin
            write_pos({1'b0, VEC[v][21:15]});
            pulse_vsync();
            run_line(VEC[v][12], VEC[v][14:13], VEC[v][14:13],
                     int'(VEC[v][11:2]), int'(VEC[v][1:0]));
        end

        // R2: bit 7 ignored on write, reads 0
        write_pos(8'hFF);
        @(negedge clk);
        check(pos_rdata_o == 8'h7F, "R2 readback bit7", int'(pos_rdata_o), 127);
        write_pos(8'h02);
        @(negedge clk);
        check(pos_rdata_o == 8'h02, "R2 readback value", int'(pos_rdata_o), 2);

        // R3: without vsync the previous working position (33) still governs
        run_line(1'b1, 2'd2, 2'd2, 197, 2);
        pulse_vsync();
        run_line(1'b1, 2'd2, 2'd2, 73, 2);

        // R9: div_sel changed after the strobe does not alter the ratio
        run_line(1'b1, 2'd3, 2'd1, 73, 3);

        // R5: inactive edge (falling with rise-active) gives no strobe
        @(negedge clk);
        hsync_i = 1'b0;
        cnt = 0;
        for (int i = 0; i < 150; i++) begin
            @(negedge clk);
            if (start_o) cnt++;
        end
        check(cnt == 0, "R5 inactive edge strobes", cnt, 0);

        // Restart dots running for R10
        run_line(1'b1, 2'd1, 2'd1, 73, 1);

        // R7 / R10: restart mid-count, dots stop
        @(negedge clk);
        hsync_i = 1'b0;
        repeat (6) @(negedge clk);
        hsync_i = 1'b1;
        cnt = 0;
        n = 0;
        for (int i = 0; i < 30; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (start_o) cnt++;
            if (i >= 3 && dot_en_o) n++;
        end
        check(n == 0, "R10 dots after new edge", n, 0);
        hsync_i = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (start_o) cnt++;
        end
        check(cnt == 0, "R7 aborted line strobe", cnt, 0);
        hsync_i = 1'b1;
        wait_start(n);
        check(n == 73, "R7 restart count", n, 73);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule